// File: doc/BRIEF.md
# Private peripheral bus decoder

This block sits in front of the private peripheral region of a microcontroller and steers one access at a time. A requester presents an offset inside the 1 MB region, a read or write flag, a size code, write data and two attributes: privileged and secure. The decoder picks a destination. It can send the access to the system-control and interrupt-controller registers, to one of two banked system timers, or to an optional reliability register block. If no target claims the offset, an internal default responder answers instead. The block returns the chosen target's read data and error flag to the requester.

Some windows overlap. The timer window lies inside the system-control window and wins over it. The default responder sits below every other target. When the v8 option is set, a second copy of the system-control window, with its timer sub-window, serves as a non-secure alias. A secure access to this alias reaches the real target with the secure attribute cleared. A non-secure access to it gets the same answer as an unclaimed address. The timer bank is chosen from the secure attribute after any alias rewrite. With the security option off, only the non-secure timer bank is ever used.

Only one access is in flight at a time. The requester waits for `req_ready` before issuing a request, and receives exactly one `rsp_valid` pulse for each accepted request.

Top module: `ppb_decoder`

## Requirements
- R1: An offset from 0xE000 to 0xEFFF that lies outside the timer window goes to the system-control port. `fwd_addr` carries the low 12 offset bits, and `fwd_secure` equals `req_secure`.
- R2: Offsets 0xE010 to 0xE0EF belong to the timer window, which takes priority over the system-control window. `fwd_addr` is the offset minus 0xE010. Offsets 0xE00C and 0xE0F0 fall outside it and go to the system-control port.
- R3: A timer-window access with the effective secure attribute at 1 goes to the secure timer port. With the attribute at 0 it goes to the non-secure timer port. When SEC_EN is 0, every timer access goes to the non-secure port.
- R4: When V8_EN is 1, offsets 0x2E000 to 0x2EFFF form an alias of the system-control window. A secure access there is decoded as if at offset − 0x20000, with `fwd_secure` forced to 0, so the timer alias reaches the non-secure timer.
- R5: The default response covers non-secure accesses to the alias, every unclaimed offset, and the alias window when V8_EN is 0. A privileged default access returns read data 0 with no error, strobes no target, and so leaves every target untouched. An unprivileged default access returns the error flag set.
- R6: When RAS_EN is 1, offsets 0x5000 to 0x5FFF go to the reliability port. `fwd_addr` carries the low 12 bits. Offset 0x6000 gets the default response.
- R7: A default response is presented as a one-cycle `rsp_valid` pulse in the cycle after acceptance. A forwarded access raises exactly one target strobe for one cycle after acceptance. The response pulse follows the cycle in which the selected target acknowledges, with that target's read data and error. Acknowledges from targets that were not selected are ignored.
- R8: `req_ready` is low from the cycle after a forwarded acceptance until the response cycle. A request offered while `req_ready` is low is ignored.
- R9: After reset, `req_ready` is 1 and `rsp_valid` and every target strobe are 0.
- R10: `fwd_write`, `fwd_wdata` and `fwd_size` carry the request's values unchanged. Size code 0, 1, 2 or 3 means 1, 2, 4 or 8 bytes, and the default responder accepts all four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder can accept a request |
| req_off | input | REGION_AW | Offset within the peripheral region |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code (log2 bytes) |
| req_wdata | input | DATA_W | Write data |
| req_priv | input | 1 | Privileged access |
| req_secure | input | 1 | Secure access |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Response read data |
| rsp_err | output | 1 | Response bus error |
| fwd_addr | output | WIN_AW | Offset within the chosen target window |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_size | output | 2 | Forwarded size code |
| fwd_wdata | output | DATA_W | Forwarded write data |
| fwd_secure | output | 1 | Forwarded secure attribute after alias rewrite |
| scs_req | output | 1 | System-control port strobe |
| scs_ack | input | 1 | System-control acknowledge |
| scs_rdata | input | DATA_W | System-control read data |
| scs_err | input | 1 | System-control error |
| tmr_s_req | output | 1 | Secure timer strobe |
| tmr_s_ack | input | 1 | Secure timer acknowledge |
| tmr_s_rdata | input | DATA_W | Secure timer read data |
| tmr_s_err | input | 1 | Secure timer error |
| tmr_ns_req | output | 1 | Non-secure timer strobe |
| tmr_ns_ack | input | 1 | Non-secure timer acknowledge |
| tmr_ns_rdata | input | DATA_W | Non-secure timer read data |
| tmr_ns_err | input | 1 | Non-secure timer error |
| ras_req | output | 1 | Reliability block strobe |
| ras_ack | input | 1 | Reliability block acknowledge |
| ras_rdata | input | DATA_W | Reliability block read data |
| ras_err | input | 1 | Reliability block error |

## Verification
Accesses are placed on each side of the timer window edges, 0xE00C and 0xE010 at the bottom, 0xE0EC and 0xE0F0 at the top. These separate the overlap priority from an off-by-one error in the window bounds. The same alias offsets are sent once with the secure attribute and once without, and an unclaimed offset is sent with both privilege levels. Comparing the pairs shows the attribute rewrite apart from the RAZ/WI versus fault choice. Several forwarded accesses have a delayed acknowledge while every other target acknowledges with an error. A competing request is also offered mid-flight. Together these confirm that only the selected target's answer returns and that a busy decoder drops new requests.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_SCS    = 3'd1,
    TGT_TMR_S  = 3'd2,
    TGT_TMR_NS = 3'd3,
    TGT_RAS    = 3'd4
  } ppb_tgt_e;

  localparam int N_PORTS    = 4;
  localparam int SCS_PAGE   = 'h0E;
  localparam int ALIAS_PAGE = 'h2E;
  localparam int RAS_PAGE   = 'h05;
  localparam int TMR_LO     = 'h010;
  localparam int TMR_END    = 'h0F0;

  // Strobe bit order: system-control, secure timer, non-secure timer, reliability.
  function automatic logic [N_PORTS-1:0] tgt_onehot(input ppb_tgt_e t);
    logic [N_PORTS-1:0] v;
    v = '0;
    case (t)
      TGT_SCS:    v[0] = 1'b1;
      TGT_TMR_S:  v[1] = 1'b1;
      TGT_TMR_NS: v[2] = 1'b1;
      TGT_RAS:    v[3] = 1'b1;
      default:    v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ppb_region_decode.sv
module ppb_region_decode
  import ppb_pkg::*;
#(
  parameter int REGION_AW = 20,
  parameter int WIN_AW    = 12,
  parameter int V8_EN     = 1,
  parameter int SEC_EN    = 1,
  parameter int RAS_EN    = 1
) (
  input  logic [REGION_AW-1:0] off,
  input  logic                 secure,
  output ppb_tgt_e             tgt,
  output logic                 fwd_secure,
  output logic [WIN_AW-1:0]    fwd_addr
);
  localparam int PAGE_W = REGION_AW - WIN_AW;

  logic [PAGE_W-1:0] page;
  logic [WIN_AW-1:0] lo;
  logic              alias_hit, family_hit, timer_hit, eff_sec, banked;

  generate
    if (SEC_EN != 0) begin : g_banked
      assign banked = 1'b1;
    end else begin : g_single
      assign banked = 1'b0;
    end
  endgenerate

  always_comb begin
    page       = off[REGION_AW-1:WIN_AW];
    lo         = off[WIN_AW-1:0];
    alias_hit  = (V8_EN != 0) && (page == PAGE_W'(ALIAS_PAGE));
    family_hit = (page == PAGE_W'(SCS_PAGE)) || (alias_hit && secure);
    eff_sec    = alias_hit ? 1'b0 : secure;
    timer_hit  = (lo >= WIN_AW'(TMR_LO)) && (lo < WIN_AW'(TMR_END));
    tgt        = TGT_NONE;
    fwd_secure = eff_sec;
    fwd_addr   = lo;
    if (family_hit) begin
      if (timer_hit) begin
        tgt      = (banked && eff_sec) ? TGT_TMR_S : TGT_TMR_NS;
        fwd_addr = lo - WIN_AW'(TMR_LO);
      end else begin
        tgt = TGT_SCS;
      end
    end else if ((RAS_EN != 0) && (page == PAGE_W'(RAS_PAGE))) begin
      tgt = TGT_RAS;
    end
  end
endmodule

// File: rtl/ppb_resp_mux.sv
module ppb_resp_mux
  import ppb_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  ppb_tgt_e            sel,
  input  logic [N_PORTS-1:0]  ack,
  input  logic [N_PORTS-1:0]  err,
  input  logic [DATA_W-1:0]   rdata [N_PORTS],
  output logic                hit,
  output logic [DATA_W-1:0]   rd,
  output logic                er
);
  logic [N_PORTS-1:0] oh;

  always_comb begin
    oh  = tgt_onehot(sel);
    hit = 1'b0;
    rd  = '0;
    er  = 1'b0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (oh[i]) begin
        hit = ack[i];
        rd  = rdata[i];
        er  = err[i];
      end
    end
  end
endmodule

// File: rtl/ppb_decoder.sv
module ppb_decoder
  import ppb_pkg::*;
#(
  parameter int REGION_AW = 20,
  parameter int WIN_AW    = 12,
  parameter int DATA_W    = 64,
  parameter int V8_EN     = 1,
  parameter int SEC_EN    = 1,
  parameter int RAS_EN    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [REGION_AW-1:0] req_off,
  input  logic                 req_write,
  input  logic [1:0]           req_size,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 req_priv,
  input  logic                 req_secure,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic [WIN_AW-1:0]    fwd_addr,
  output logic                 fwd_write,
  output logic [1:0]           fwd_size,
  output logic [DATA_W-1:0]    fwd_wdata,
  output logic                 fwd_secure,
  output logic                 scs_req,
  input  logic                 scs_ack,
  input  logic [DATA_W-1:0]    scs_rdata,
  input  logic                 scs_err,
  output logic                 tmr_s_req,
  input  logic                 tmr_s_ack,
  input  logic [DATA_W-1:0]    tmr_s_rdata,
  input  logic                 tmr_s_err,
  output logic                 tmr_ns_req,
  input  logic                 tmr_ns_ack,
  input  logic [DATA_W-1:0]    tmr_ns_rdata,
  input  logic                 tmr_ns_err,
  output logic                 ras_req,
  input  logic                 ras_ack,
  input  logic [DATA_W-1:0]    ras_rdata,
  input  logic                 ras_err
);
  localparam int PAGE_W = REGION_AW - WIN_AW;

  ppb_tgt_e            dec_tgt, tgt_q;
  logic                dec_sec;
  logic [WIN_AW-1:0]   dec_addr;
  logic                wait_q, accept;
  logic [N_PORTS-1:0]  strb_q, ack_v, err_v;
  logic [DATA_W-1:0]   rd_arr [N_PORTS];
  logic                sel_ack, sel_err;
  logic [DATA_W-1:0]   sel_rd;

  ppb_region_decode #(
    .REGION_AW(REGION_AW), .WIN_AW(WIN_AW),
    .V8_EN(V8_EN), .SEC_EN(SEC_EN), .RAS_EN(RAS_EN)
  ) u_decode (
    .off(req_off), .secure(req_secure),
    .tgt(dec_tgt), .fwd_secure(dec_sec), .fwd_addr(dec_addr)
  );

  assign ack_v     = {ras_ack, tmr_ns_ack, tmr_s_ack, scs_ack};
  assign err_v     = {ras_err, tmr_ns_err, tmr_s_err, scs_err};
  assign rd_arr[0] = scs_rdata;
  assign rd_arr[1] = tmr_s_rdata;
  assign rd_arr[2] = tmr_ns_rdata;
  assign rd_arr[3] = ras_rdata;

  ppb_resp_mux #(.DATA_W(DATA_W)) u_mux (
    .sel(tgt_q), .ack(ack_v), .err(err_v), .rdata(rd_arr),
    .hit(sel_ack), .rd(sel_rd), .er(sel_err)
  );

  assign req_ready  = !wait_q;
  assign accept     = req_valid && !wait_q;
  assign scs_req    = strb_q[0];
  assign tmr_s_req  = strb_q[1];
  assign tmr_ns_req = strb_q[2];
  assign ras_req    = strb_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q     <= 1'b0;
      strb_q     <= '0;
      tgt_q      <= TGT_NONE;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_err    <= 1'b0;
      fwd_addr   <= '0;
      fwd_write  <= 1'b0;
      fwd_size   <= '0;
      fwd_wdata  <= '0;
      fwd_secure <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      strb_q    <= '0;
      if (accept) begin
        tgt_q <= dec_tgt;
        if (dec_tgt == TGT_NONE) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
          rsp_err   <= !req_priv;
        end else begin
          wait_q     <= 1'b1;
          strb_q     <= tgt_onehot(dec_tgt);
          fwd_addr   <= dec_addr;
          fwd_write  <= req_write;
          fwd_size   <= req_size;
          fwd_wdata  <= req_wdata;
          fwd_secure <= dec_sec;
        end
      end else if (wait_q && sel_ack) begin
        wait_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_rdata <= sel_rd;
        rsp_err   <= sel_err;
      end
    end
  end

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb_q));

  assert_strobe_follows_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (|strb_q) |-> $past(req_valid && req_ready));

  assert_busy_while_strobing_R8: assert property (@(posedge clk) disable iff (rst)
    (|strb_q) |-> !req_ready);

  assert_ready_with_response_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  assert_alias_clears_secure_R4: assert property (@(posedge clk) disable iff (rst)
    ((|strb_q) && $past((V8_EN != 0) && (req_off[REGION_AW-1:WIN_AW] == PAGE_W'(ALIAS_PAGE))))
      |-> !fwd_secure);

  assert_default_raz_or_fault_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_valid && req_ready && (dec_tgt == TGT_NONE)))
      |-> (rsp_rdata == '0 && rsp_err == !$past(req_priv)));

  generate
    if (SEC_EN == 0) begin : g_chk_single
      assert_no_secure_timer_R3: assert property (@(posedge clk) disable iff (rst)
        !tmr_s_req);
    end
  endgenerate
endmodule

// File: tb/ppb_decoder_bench.sv
`timescale 1ns/1ps
module ppb_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, req_secure = 1'b0;
  logic [19:0] req_off = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata, fwd_wdata;
  logic [11:0] fwd_addr;
  logic        fwd_write, fwd_secure;
  logic [1:0]  fwd_size;
  logic        scs_req, tmr_s_req, tmr_ns_req, ras_req;
  logic [3:0]  t_ack = '0, t_err = '0;
  logic [63:0] t_rd [4];

  int checks = 0, errors = 0;
  int cur_delay = 0;
  bit cur_terr = 0, noise_on = 0;
  bit pend = 0;
  int pend_id = 0, pend_cnt = 0;

  ppb_decoder u_ppb_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_off(req_off), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .req_priv(req_priv), .req_secure(req_secure),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .fwd_addr(fwd_addr), .fwd_write(fwd_write), .fwd_size(fwd_size),
    .fwd_wdata(fwd_wdata), .fwd_secure(fwd_secure),
    .scs_req(scs_req), .scs_ack(t_ack[0]), .scs_rdata(t_rd[0]), .scs_err(t_err[0]),
    .tmr_s_req(tmr_s_req), .tmr_s_ack(t_ack[1]), .tmr_s_rdata(t_rd[1]), .tmr_s_err(t_err[1]),
    .tmr_ns_req(tmr_ns_req), .tmr_ns_ack(t_ack[2]), .tmr_ns_rdata(t_rd[2]), .tmr_ns_err(t_err[2]),
    .ras_req(ras_req), .ras_ack(t_ack[3]), .ras_rdata(t_rd[3]), .ras_err(t_err[3])
  );

  function automatic logic [63:0] tgt_word(input int id, input int addr);
    return 64'hA5A5_0000_0000_0000 | (64'(id) << 16) | 64'(addr);
  endfunction

  // Target models: answer a strobe after cur_delay cycles; optional noise from the others.
  always @(negedge clk) begin
    logic [3:0] s;
    s = {ras_req, tmr_ns_req, tmr_s_req, scs_req};
    for (int i = 0; i < 4; i++) begin
      t_ack[i] = noise_on;
      t_err[i] = noise_on;
      t_rd[i]  = 64'hDEAD_DEAD_DEAD_DEAD;
    end
    if (s != 0) begin
      pend = 1;
      pend_cnt = cur_delay;
      for (int i = 0; i < 4; i++) if (s[i]) pend_id = i;
    end
    if (pend) begin
      t_ack[pend_id] = 1'b0;
      t_err[pend_id] = 1'b0;
      if (pend_cnt == 0) begin
        t_ack[pend_id] = 1'b1;
        t_err[pend_id] = cur_terr;
        t_rd[pend_id]  = tgt_word(pend_id, int'(fwd_addr));
        pend = 0;
      end else begin
        pend_cnt--;
      end
    end
  end

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  // Behavioural expectation: 0 default, 1 control, 2 secure timer, 3 non-secure timer, 4 reliability.
  task automatic model(input int off, input bit sec, output int t, output int faddr, output bit fsec);
    int page, lo;
    bit al, fam, es;
    page = off >> 12;
    lo = off & 'hFFF;
    al = (page == 'h2E);
    fam = (page == 'h0E) || (al && sec);
    es = al ? 1'b0 : sec;
    t = 0; faddr = lo; fsec = es;
    if (fam) begin
      if (lo >= 'h10 && lo < 'hF0) begin t = es ? 2 : 3; faddr = lo - 'h10; end
      else t = 1;
    end else if (page == 'h05) t = 4;
  endtask

  task automatic access(input string r, input int off, input bit wr, input logic [1:0] sz,
                        input bit priv, input bit sec, input int delay, input bit terr,
                        input bit noise, input bit inject);
    int t, fa;
    bit fs;
    logic [3:0] ev;
    logic [63:0] wd;
    model(off, sec, t, fa, fs);
    ev = (t == 0) ? 4'b0 : 4'(1 << (t - 1));
    wd = {32'hC0DE_0000 | 32'(off), 32'(off) ^ 32'h5A5A_5A5A};
    @(negedge clk);
    cur_delay = delay; cur_terr = terr; noise_on = noise;
    req_valid = 1; req_off = 20'(off); req_write = wr; req_size = sz;
    req_wdata = wd; req_priv = priv; req_secure = sec;
    @(negedge clk);
    req_valid = 0;
    chk(r, "strobes", {60'b0, ras_req, tmr_ns_req, tmr_s_req, scs_req}, {60'b0, ev});
    if (t == 0) begin
      chk(r, "default rsp_valid", rsp_valid, 1);
      chk(r, "default rdata", rsp_rdata, 0);
      chk(r, "default err", rsp_err, !priv);
      chk(r, "default ready", req_ready, 1);
    end else begin
      chk(r, "fwd_addr", fwd_addr, fa);
      chk(r, "fwd_secure", fwd_secure, fs);
      chk("R10", "fwd_write", fwd_write, wr);
      chk("R10", "fwd_size", fwd_size, sz);
      chk("R10", "fwd_wdata", fwd_wdata, wd);
      chk("R7", "no early rsp", rsp_valid, 0);
      chk("R8", "busy ready", req_ready, 0);
      for (int k = 0; k <= delay; k++) begin
        @(negedge clk);
        if (inject && k == 0 && delay > 0) begin
          req_valid = 1; req_off = 20'h01000; req_priv = 0; req_secure = 0;
        end else req_valid = 0;
        chk("R7", "rsp_valid timing", rsp_valid, k == delay);
        chk("R7", "strobes idle", {ras_req, tmr_ns_req, tmr_s_req, scs_req}, 0);
        chk("R8", "ready", req_ready, k == delay);
        if (k == delay) begin
          chk("R7", "rsp rdata", rsp_rdata, tgt_word(t - 1, fa));
          chk("R7", "rsp err", rsp_err, terr);
        end
      end
    end
    req_valid = 0;
    @(negedge clk);
    chk("R8", "single response", rsp_valid, 0);
    chk("R8", "no stray strobe", {ras_req, tmr_ns_req, tmr_s_req, scs_req}, 0);
    noise_on = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9", "reset ready", req_ready, 1);
    chk("R9", "reset rsp_valid", rsp_valid, 0);
    chk("R9", "reset strobes", {ras_req, tmr_ns_req, tmr_s_req, scs_req}, 0);
    access("R1", 'hE100, 0, 2, 1, 1, 0, 0, 0, 0);
    access("R1", 'hED04, 1, 3, 1, 0, 1, 0, 0, 0);
    access("R2", 'hE00C, 0, 2, 1, 1, 0, 0, 0, 0);
    access("R2", 'hE0F0, 1, 2, 1, 0, 0, 0, 0, 0);
    access("R3", 'hE010, 0, 2, 1, 1, 2, 0, 0, 0);
    access("R3", 'hE0EC, 1, 2, 0, 0, 0, 1, 0, 0);
    access("R4", 'h2E020, 0, 2, 1, 1, 1, 0, 0, 0);
    access("R4", 'h2ED00, 1, 2, 1, 1, 0, 0, 0, 0);
    access("R5", 'h2E020, 0, 2, 1, 0, 0, 0, 0, 0);
    access("R5", 'h2ED00, 1, 2, 0, 0, 0, 0, 0, 0);
    access("R5", 'h01000, 1, 0, 1, 1, 0, 0, 0, 0);
    access("R5", 'h01000, 0, 3, 0, 1, 0, 0, 0, 0);
    access("R10", 'hFFFFC, 0, 1, 1, 0, 0, 0, 0, 0);
    access("R6", 'h5008, 1, 2, 1, 0, 0, 0, 0, 0);
    access("R6", 'h6000, 0, 2, 0, 0, 0, 0, 0, 0);
    access("R7", 'hE200, 0, 2, 1, 0, 3, 1, 1, 0);
    access("R7", 'hE040, 0, 2, 1, 1, 2, 0, 1, 0);
    access("R8", 'h5010, 0, 2, 1, 0, 3, 0, 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule